// File: doc/BRIEF.md
# Chained Layer Pixel Combiner

This block merges several input pixel pipes into one or more output streams through a pool of combining stages. Each stage takes one input pipe as its top layer. A stage in blending mode may also take the result of another stage as its bottom layer, so the stages form a linked chain. The stage that ends a chain fills its bottom layer with its own background colour. A selector for each output names the stage at the head of that output's chain.

Every stage keeps its settings in shadow registers. Each setting is written through a narrow write port. A setting becomes active when its update pulse arrives, unless the lock for the chosen output holds it back. Each stage also reports whether it is idle and whether it is busy. All output pixels and status bits are registered, so they appear one clock after the inputs and the active settings that produce them.

Top module: `pixmix_top`

## Requirements
- R1: After a synchronous reset, the following values hold. All top selects, bottom selects, output ids, lock selects and output selectors are 0xF. Global alpha and gain are 0xFF. Mode is 0 and backgrounds are 0. The outputs show out_valid=0, st_idle all ones and st_busy all zeros.
- R2: A write with wr_en sets the field wr_addr[3:0] of the stage wr_addr[7:4]. The field codes are 0 top select, 1 bottom select, 2 output id, 3 lock select, 4 control, 5 global alpha, 6 gain, 7/8/9 background red/green/blue, and 15 the output selector of output wr_addr[7:4]. The control bits are [1:0] mode, [2] global-alpha-only, [3] premultiplied and [4] overlap-only. A background channel stores the 10-bit data shifted left by 2.
- R3: Field writes other than the lock select go to shadow copies. A stage whose lock select names an output copies its shadow on that output's vupd pulse. When the lock select names no output, the stage copies its shadow every cycle. An output selector copies on its own output's vupd pulse. Without a pulse, the active setting stays unchanged.
- R4: While lock[o] is high, a vupd[o] pulse copies nothing for output o's selector or for the stages locked to o.
- R5: Each output is registered one cycle after its inputs. If the active selector is 0xF or not below the stage count, out_valid=0 and out_pix=0. An invalid stage result also gives pixel 0. No output is valid unless some input pipe is valid.
- R6: Mode 0 (top only) blends the top pipe over the stage's background. The result is valid when the top pipe is connected and valid.
- R7: Mode 1 (passthrough) outputs the top pixel unchanged, with no alpha and no gain applied.
- R8: Mode 2 (blend) takes stage b as the bottom layer when the bottom select b is greater than the stage's own index and less than the stage count. Any other value, including the stage's own index, counts as unconnected, and the stage then behaves as in mode 0.
- R9: Arithmetic per 12-bit channel works as follows. Let x(v)=v+v[7]. The effective alpha is e=(x(pa)·x(ga))>>8. The top term is T=(((top·e)>>8)·x(gain))>>8 and the bottom term is B=(bot·(256−e))>>8. The result is min(T+B, 4095), and the pixel word is {R,G,B} with R in the top bits.
- R10: Global-alpha-only sets e=x(ga). The premultiplied setting replaces e with x(ga) in the top term only.
- R11: With overlap-only set in linked blend mode, blending happens only when both layers are valid. If exactly one layer is valid, that layer passes through raw.
- R12: st_idle[s]=1 exactly when the active top select and output id of stage s are both 0xF. st_busy[s]=1 when its connected top pipe is valid, or when it is a linked blend stage whose bottom stage is valid. Both status outputs are registered.
- R13: In linked blend mode without overlap-only, a missing top layer yields the bottom result unchanged. A missing bottom layer is replaced by the background. The result is valid if either layer is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | field write strobe |
| wr_addr | input | 8 | {stage or output index, field code} |
| wr_data | input | 10 | field value |
| vupd | input | NOUT | update pulse per output |
| lock | input | NOUT | update lock per output |
| in_valid | input | NPIPE | pixel valid per input pipe |
| in_alpha | input | NPIPE*8 | pixel alpha per pipe |
| in_pix | input | NPIPE*36 | {R,G,B} 12-bit channels per pipe |
| out_valid | output | NOUT | output pixel valid |
| out_pix | output | NOUT*36 | output {R,G,B} |
| st_idle | output | NSTAGE | stage idle flags |
| st_busy | output | NSTAGE | stage busy flags |

## Verification
A shadow write reaches the outputs two cycles after its write edge when the stage is not locked to an output. Otherwise it takes effect one cycle after the vupd edge that copies it. Pixel results and status flags appear at the clock edge that follows the edge at which the inputs are driven. The driver therefore changes inputs on falling edges, allows two idle cycles after each configuration change, and queues one expected result per output. The monitor then compares that result just after the next rising edge.

// File: rtl/pixmix_pkg.sv
`timescale 1ns/1ps
package pixmix_pkg;
  localparam int CW    = 12;
  localparam int PXW   = 3 * CW;
  localparam int AW    = 8;
  localparam int SELW  = 4;
  localparam int WDW   = 10;
  localparam logic [SELW-1:0] SEL_NONE = '1;
  localparam logic [CW-1:0]   CH_MAX   = '1;

  localparam logic [3:0] F_TOP = 4'd0, F_BOT = 4'd1, F_OUT = 4'd2, F_LOCK = 4'd3,
                         F_CTRL = 4'd4, F_GALPHA = 4'd5, F_GAIN = 4'd6,
                         F_BGR = 4'd7, F_BGG = 4'd8, F_BGB = 4'd9, F_MUX = 4'd15;

  typedef logic [SELW-1:0] sel_t;
  typedef logic [CW-1:0]   chan_t;
  typedef enum logic [1:0] {MD_TOP, MD_PASS, MD_BLEND, MD_RSVD} mode_e;

  typedef struct packed {
    chan_t r;
    chan_t g;
    chan_t b;
  } px_t;

  typedef struct packed {
    sel_t           top_sel;
    sel_t           bot_sel;
    sel_t           out_id;
    mode_e          mode;
    logic           amode;
    logic           premul;
    logic           overlap;
    logic [AW-1:0]  galpha;
    logic [AW-1:0]  gain;
    px_t            bg;
  } cfg_t;

  localparam cfg_t CFG_RST = '{top_sel: SEL_NONE, bot_sel: SEL_NONE, out_id: SEL_NONE,
                               mode: MD_TOP, amode: 1'b0, premul: 1'b0, overlap: 1'b0,
                               galpha: '1, gain: '1, bg: '0};

  // 8-bit factor expanded so that 255 maps to a full-scale 256
  function automatic logic [AW:0] expand(input logic [AW-1:0] v);
    return {1'b0, v} + {{AW{1'b0}}, v[AW-1]};
  endfunction

  function automatic chan_t mix_ch(input chan_t t, input chan_t b, input logic [AW:0] eff,
                                   input logic [AW:0] tsc, input logic [AW:0] gn);
    logic [CW+AW:0] tt, bt;
    logic [CW:0]    sum;
    tt  = ((CW+AW+1)'(t) * (CW+AW+1)'(tsc)) >> AW;
    tt  = (tt * (CW+AW+1)'(gn)) >> AW;
    bt  = ((CW+AW+1)'(b) * (CW+AW+1)'(9'd256 - eff)) >> AW;
    sum = (CW+1)'(tt) + (CW+1)'(bt);
    return sum[CW] ? CH_MAX : sum[CW-1:0];
  endfunction

  function automatic px_t mix_px(input px_t t, input px_t b, input logic [AW:0] eff,
                                 input logic [AW:0] tsc, input logic [AW:0] gn);
    px_t o;
    o.r = mix_ch(t.r, b.r, eff, tsc, gn);
    o.g = mix_ch(t.g, b.g, eff, tsc, gn);
    o.b = mix_ch(t.b, b.b, eff, tsc, gn);
    return o;
  endfunction
endpackage

// File: rtl/pixmix_stage_regs.sv
`timescale 1ns/1ps
module pixmix_stage_regs import pixmix_pkg::*; #(
  parameter int IDX  = 0,
  parameter int NOUT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [3:0]      wr_fld,
  input  logic [WDW-1:0]  wr_data,
  input  logic [NOUT-1:0] vupd,
  input  logic [NOUT-1:0] lock,
  output cfg_t            act
);
  cfg_t shd;
  sel_t lock_sel;
  logic hit, upd;

  assign hit = wr_en && (32'(wr_idx) == IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      shd      <= CFG_RST;
      lock_sel <= SEL_NONE;
    end else if (hit) begin
      case (wr_fld)
        F_TOP:    shd.top_sel <= wr_data[SELW-1:0];
        F_BOT:    shd.bot_sel <= wr_data[SELW-1:0];
        F_OUT:    shd.out_id  <= wr_data[SELW-1:0];
        F_LOCK:   lock_sel    <= wr_data[SELW-1:0];
        F_CTRL: begin
          shd.mode    <= mode_e'(wr_data[1:0]);
          shd.amode   <= wr_data[2];
          shd.premul  <= wr_data[3];
          shd.overlap <= wr_data[4];
        end
        F_GALPHA: shd.galpha <= wr_data[AW-1:0];
        F_GAIN:   shd.gain   <= wr_data[AW-1:0];
        F_BGR:    shd.bg.r   <= {wr_data[CW-3:0], 2'b00};
        F_BGG:    shd.bg.g   <= {wr_data[CW-3:0], 2'b00};
        F_BGB:    shd.bg.b   <= {wr_data[CW-3:0], 2'b00};
        default: ;
      endcase
    end
  end

  // copy condition: the chosen output's pulse without its lock, or always when none is chosen
  always_comb begin
    upd = 1'b1;
    for (int o = 0; o < NOUT; o++)
      if (32'(lock_sel) == o) upd = vupd[o] & ~lock[o];
  end

  always_ff @(posedge clk) begin
    if (rst)      act <= CFG_RST;
    else if (upd) act <= shd;
  end
endmodule

// File: rtl/pixmix_chain.sv
`timescale 1ns/1ps
module pixmix_chain import pixmix_pkg::*; #(
  parameter int NPIPE  = 4,
  parameter int NSTAGE = 4
) (
  input  cfg_t                  cfg [NSTAGE],
  input  logic [NPIPE-1:0]      in_valid,
  input  logic [NPIPE*AW-1:0]   in_alpha,
  input  logic [NPIPE*PXW-1:0]  in_pix,
  output logic [NSTAGE-1:0]     sv,
  output px_t  [NSTAGE-1:0]     spx,
  output logic [NSTAGE-1:0]     idle,
  output logic [NSTAGE-1:0]     busy
);
  // stages evaluated from the highest index down; a bottom link may only point upward
  always_comb begin
    logic          tv, bv, bcon;
    px_t           tpx, bpx;
    logic [AW-1:0] pa;
    logic [AW:0]   eff, tsc;
    sv   = '0;
    spx  = '0;
    idle = '0;
    busy = '0;
    for (int i = NSTAGE - 1; i >= 0; i--) begin
      tv = 1'b0; tpx = '0; pa = '0;
      for (int p = 0; p < NPIPE; p++)
        if (32'(cfg[i].top_sel) == p) begin
          tv  = in_valid[p];
          tpx = in_pix[p*PXW +: PXW];
          pa  = in_alpha[p*AW +: AW];
        end
      bcon = (32'(cfg[i].bot_sel) > i) && (32'(cfg[i].bot_sel) < NSTAGE);
      bv = 1'b0; bpx = cfg[i].bg;
      for (int q = 0; q < NSTAGE; q++)
        if (bcon && 32'(cfg[i].bot_sel) == q && sv[q]) begin
          bv  = 1'b1;
          bpx = spx[q];
        end
      eff = cfg[i].amode ? expand(cfg[i].galpha)
                         : (AW+1)'((18'(expand(pa)) * 18'(expand(cfg[i].galpha))) >> AW);
      tsc = cfg[i].premul ? expand(cfg[i].galpha) : eff;
      if (!tv) begin
        eff = '0;
        tsc = '0;
      end
      if (cfg[i].mode == MD_PASS) begin
        sv[i]  = tv;
        spx[i] = tpx;
      end else if (cfg[i].mode == MD_BLEND && bcon) begin
        sv[i] = tv | bv;
        if (cfg[i].overlap && !(tv && bv)) spx[i] = tv ? tpx : bpx;
        else spx[i] = mix_px(tpx, bpx, eff, tsc, expand(cfg[i].gain));
      end else begin
        sv[i]  = tv;
        spx[i] = mix_px(tpx, cfg[i].bg, eff, tsc, expand(cfg[i].gain));
      end
      if (!sv[i]) spx[i] = '0;
      idle[i] = (cfg[i].top_sel == SEL_NONE) && (cfg[i].out_id == SEL_NONE);
      busy[i] = tv | (cfg[i].mode == MD_BLEND && bcon && bv);
    end
  end
endmodule

// File: rtl/pixmix_top.sv
`timescale 1ns/1ps
module pixmix_top import pixmix_pkg::*; #(
  parameter int NPIPE  = 4,
  parameter int NSTAGE = 4,
  parameter int NOUT   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [7:0]           wr_addr,
  input  logic [WDW-1:0]       wr_data,
  input  logic [NOUT-1:0]      vupd,
  input  logic [NOUT-1:0]      lock,
  input  logic [NPIPE-1:0]     in_valid,
  input  logic [NPIPE*AW-1:0]  in_alpha,
  input  logic [NPIPE*PXW-1:0] in_pix,
  output logic [NOUT-1:0]      out_valid,
  output logic [NOUT*PXW-1:0]  out_pix,
  output logic [NSTAGE-1:0]    st_idle,
  output logic [NSTAGE-1:0]    st_busy
);
  cfg_t                     act [NSTAGE];
  logic [NOUT-1:0][SELW-1:0] om_shd, om_act;
  logic [NSTAGE-1:0]        sv, idle_c, busy_c;
  px_t  [NSTAGE-1:0]        spx;
  logic [3:0]               wr_idx, wr_fld;

  assign wr_idx = wr_addr[7:4];
  assign wr_fld = wr_addr[3:0];

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    pixmix_stage_regs #(.IDX(s), .NOUT(NOUT)) regs_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_fld(wr_fld),
      .wr_data(wr_data), .vupd(vupd), .lock(lock), .act(act[s]));
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_omux
    always_ff @(posedge clk) begin
      if (rst) begin
        om_shd[o] <= SEL_NONE;
        om_act[o] <= SEL_NONE;
      end else begin
        if (wr_en && wr_fld == F_MUX && 32'(wr_idx) == o) om_shd[o] <= wr_data[SELW-1:0];
        if (vupd[o] && !lock[o]) om_act[o] <= om_shd[o];
      end
    end
  end

  pixmix_chain #(.NPIPE(NPIPE), .NSTAGE(NSTAGE)) chain_i (
    .cfg(act), .in_valid(in_valid), .in_alpha(in_alpha), .in_pix(in_pix),
    .sv(sv), .spx(spx), .idle(idle_c), .busy(busy_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      out_pix   <= '0;
      st_idle   <= '1;
      st_busy   <= '0;
    end else begin
      st_idle <= idle_c;
      st_busy <= busy_c;
      for (int o = 0; o < NOUT; o++) begin
        out_valid[o]            <= 1'b0;
        out_pix[o*PXW +: PXW]   <= '0;
        for (int s = 0; s < NSTAGE; s++)
          if (32'(om_act[o]) == s) begin
            out_valid[o]          <= sv[s];
            out_pix[o*PXW +: PXW] <= spx[s];
          end
      end
    end
  end
endmodule

// File: rtl/pixmix_chk.sv
`timescale 1ns/1ps
module pixmix_chk #(
  parameter int NPIPE  = 4,
  parameter int NSTAGE = 4,
  parameter int NOUT   = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NOUT-1:0]           vupd,
  input logic [NOUT-1:0]           lock,
  input logic [NPIPE-1:0]          in_valid,
  input logic [NOUT-1:0]           out_valid,
  input logic [NSTAGE-1:0]         st_idle,
  input logic [NSTAGE-1:0]         st_busy,
  input logic [NOUT-1:0][3:0]      om_act
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && st_idle == '1 && st_busy == '0)); // R1

  AST_QUIET_INPUTS: assert property (@(posedge clk) disable iff (rst)
    (in_valid == '0) |=> (out_valid == '0)); // R5

  AST_QUIET_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (in_valid == '0) |=> (st_busy == '0)); // R12

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    AST_SEL_NONE: assert property (@(posedge clk) disable iff (rst)
      (om_act[o] == 4'hF) |=> !out_valid[o]); // R5

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
      lock[o] |=> $stable(om_act[o])); // R4

    AST_NO_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !vupd[o] |=> $stable(om_act[o])); // R3
  end
endmodule

bind pixmix_top pixmix_chk #(.NPIPE(NPIPE), .NSTAGE(NSTAGE), .NOUT(NOUT)) chk_i (
  .clk(clk), .rst(rst), .vupd(vupd), .lock(lock), .in_valid(in_valid),
  .out_valid(out_valid), .st_idle(st_idle), .st_busy(st_busy), .om_act(om_act));

// File: tb/pixmix_top_tb_top.sv
`timescale 1ns/1ps
module pixmix_top_tb_top;
  localparam int NPIPE = 4, NSTAGE = 4, NOUT = 2, PW = 36;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic [NOUT-1:0] vupd = '0, lock = '0;
  logic [NPIPE-1:0] in_valid = '0;
  logic [NPIPE*8-1:0] in_alpha = '0;
  logic [NPIPE*PW-1:0] in_pix = '0;
  logic [NOUT-1:0] out_valid;
  logic [NOUT*PW-1:0] out_pix;
  logic [NSTAGE-1:0] st_idle, st_busy;

  int total = 0, bad = 0;

  typedef struct {
    int          o;
    logic        v;
    logic [35:0] px;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  pixmix_top #(.NPIPE(NPIPE), .NSTAGE(NSTAGE), .NOUT(NOUT)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vupd(vupd), .lock(lock), .in_valid(in_valid), .in_alpha(in_alpha), .in_pix(in_pix),
    .out_valid(out_valid), .out_pix(out_pix), .st_idle(st_idle), .st_busy(st_busy));

  function automatic logic [35:0] px(int r, int g, int b);
    return {12'(r), 12'(g), 12'(b)};
  endfunction

  function automatic int ex(int v);
    return v + ((v >= 128) ? 1 : 0);
  endfunction

  function automatic int rch(int t, int b, int pa, int ga, int gn, int am, int pm);
    int e, ts, tt, bt;
    e  = am ? ex(ga) : (ex(pa) * ex(ga)) >> 8;
    ts = pm ? ex(ga) : e;
    tt = (((t * ts) >> 8) * ex(gn)) >> 8;
    bt = (b * (256 - e)) >> 8;
    return (tt + bt > 4095) ? 4095 : tt + bt;
  endfunction

  function automatic logic [35:0] rmix(logic [35:0] t, logic [35:0] b, int pa, int ga,
                                       int gn, int am, int pm);
    return px(rch(int'(t[35:24]), int'(b[35:24]), pa, ga, gn, am, pm),
              rch(int'(t[23:12]), int'(b[23:12]), pa, ga, gn, am, pm),
              rch(int'(t[11:0]),  int'(b[11:0]),  pa, ga, gn, am, pm));
  endfunction

  task automatic chk(logic ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wr(int idx, int fld, int data);
    wr_en = 1'b1; wr_addr = {4'(idx), 4'(fld)}; wr_data = 10'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(logic [NOUT-1:0] m);
    vupd = m;
    @(negedge clk);
    vupd = '0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pipe(int p, logic v, int a, logic [35:0] pxv);
    in_valid[p] = v;
    in_alpha[p*8 +: 8] = 8'(a);
    in_pix[p*PW +: PW] = pxv;
  endtask

  // driver side of the scoreboard: queue the result due after the next rising edge
  task automatic expect_out(int o, logic v, logic [35:0] pxv, string tag);
    item_t it;
    it.o = o; it.v = v; it.px = v ? pxv : '0; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic status(logic [3:0] idle_e, logic [3:0] busy_e, string tag);
    @(posedge clk); #1;
    chk(st_idle === idle_e, {tag, " idle"}, int'(st_idle), int'(idle_e));
    chk(st_busy === busy_e, {tag, " busy"}, int'(st_busy), int'(busy_e));
    @(negedge clk);
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(posedge clk); #1;
      while (sbq.size() > 0) begin
        item_t it;
        logic [35:0] got;
        it  = sbq.pop_front();
        got = out_pix[it.o*PW +: PW];
        total++;
        if (out_valid[it.o] !== it.v || got !== it.px) begin
          bad++;
          $display("FAIL %s: out%0d actual v=%0b px=%h expected v=%0b px=%h",
                   it.tag, it.o, out_valid[it.o], got, it.v, it.px);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [35:0] A, A2, B, BG;

  initial begin
    A  = px(1000, 2000, 3000);
    A2 = px(4000, 50, 1000);
    B  = px(3000, 100, 2000);
    BG = px(400, 800, 1200);
    settle(3);
    rst = 1'b0;
    #1;
    chk(out_valid === '0, "R1 out_valid", int'(out_valid), 0);
    chk(st_idle === 4'hF && st_busy === 4'h0, "R1 status", int'({st_idle, st_busy}), 'hF0);
    @(negedge clk);
    for (int p = 0; p < NPIPE; p++) pipe(p, 1'b1, 255, A);
    expect_out(0, 1'b0, '0, "R1 selector none");
    expect_out(1, 1'b0, '0, "R5 selector none");
    settle(1);
    for (int p = 0; p < NPIPE; p++) pipe(p, 1'b0, 0, '0);

    // R2 R6: single stage, top only, over background
    wr(0, 0, 0); wr(0, 7, 100); wr(0, 8, 200); wr(0, 9, 300);
    wr(0, 15, 0); wr(1, 15, 5);
    pulse(2'b11); settle(2);
    pipe(0, 1'b1, 255, A);
    expect_out(0, 1'b1, A, "R6 opaque top");
    expect_out(1, 1'b0, '0, "R5 selector beyond count");
    settle(1);
    pipe(0, 1'b1, 0, A);
    expect_out(0, 1'b1, BG, "R2 R6 background shifted");
    settle(1);
    pipe(0, 1'b1, 128, A);
    expect_out(0, 1'b1, rmix(A, BG, 128, 255, 255, 0, 0), "R9 half alpha");
    settle(1);
    pipe(0, 1'b0, 128, A);
    expect_out(0, 1'b0, '0, "R6 top invalid");
    settle(1);

    // R12 status
    pipe(0, 1'b1, 255, A);
    status(4'b1110, 4'b0001, "R12 top connected");
    wr(2, 2, 1); settle(2);
    status(4'b1010, 4'b0001, "R12 output id set");

    // R7 passthrough
    wr(0, 4, 1); settle(2);
    pipe(0, 1'b1, 0, A);
    expect_out(0, 1'b1, A, "R7 passthrough");
    settle(1);

    // R8 linked chain: stage1 carries pipe1, stage0 blends over it
    wr(1, 0, 1); wr(0, 1, 1); wr(0, 4, 2); settle(2);
    pipe(1, 1'b1, 255, B); pipe(0, 1'b1, 128, A);
    expect_out(0, 1'b1, rmix(A, B, 128, 255, 255, 0, 0), "R8 chain blend");
    settle(1);
    status(4'b1000, 4'b0011, "R12 chain busy");

    // R13 missing layers
    pipe(0, 1'b0, 128, A);
    expect_out(0, 1'b1, B, "R13 top missing");
    settle(1);
    pipe(0, 1'b1, 128, A); pipe(1, 1'b0, 255, B);
    expect_out(0, 1'b1, rmix(A, BG, 128, 255, 255, 0, 0), "R13 bottom missing");
    settle(1);
    pipe(0, 1'b0, 128, A);
    expect_out(0, 1'b0, '0, "R13 both missing");
    settle(1);

    // R11 overlap only
    wr(0, 4, 'h12); settle(2);
    pipe(0, 1'b1, 128, A);
    expect_out(0, 1'b1, A, "R11 top alone raw");
    settle(1);
    pipe(0, 1'b0, 128, A); pipe(1, 1'b1, 255, B);
    expect_out(0, 1'b1, B, "R11 bottom alone raw");
    settle(1);
    pipe(0, 1'b1, 128, A);
    expect_out(0, 1'b1, rmix(A, B, 128, 255, 255, 0, 0), "R11 overlap blend");
    settle(1);

    // R8 self link counts as unconnected
    wr(0, 4, 2); wr(0, 1, 0); settle(2);
    expect_out(0, 1'b1, rmix(A, BG, 128, 255, 255, 0, 0), "R8 self link");
    settle(1);

    // R9 R10 gain, global alpha only, premultiplied with saturation
    wr(0, 1, 1); wr(0, 6, 'h80); settle(2);
    expect_out(0, 1'b1, rmix(A, B, 128, 255, 'h80, 0, 0), "R9 gain");
    settle(1);
    wr(0, 6, 255); wr(0, 5, 'h40); wr(0, 4, 'h06); settle(2);
    expect_out(0, 1'b1, rmix(A, B, 128, 'h40, 255, 1, 0), "R10 global alpha only");
    settle(1);
    wr(0, 5, 255); wr(0, 4, 'h0A); settle(2);
    pipe(0, 1'b1, 0, A2);
    expect_out(0, 1'b1, rmix(A2, B, 0, 255, 255, 0, 1), "R9 R10 premultiplied saturate");
    settle(1);

    // R3 R4 lock select and lock
    wr(0, 3, 0);
    lock = 2'b01;
    wr(0, 4, 1); pulse(2'b01); settle(2);
    expect_out(0, 1'b1, rmix(A2, B, 0, 255, 255, 0, 1), "R4 locked stage");
    settle(1);
    lock = 2'b00; settle(2);
    expect_out(0, 1'b1, rmix(A2, B, 0, 255, 255, 0, 1), "R3 no pulse");
    settle(1);
    pulse(2'b01);
    expect_out(0, 1'b1, A2, "R3 after pulse");
    settle(1);
    lock = 2'b01;
    wr(0, 15, 15); pulse(2'b01); settle(1);
    expect_out(0, 1'b1, A2, "R4 selector locked");
    settle(1);
    lock = 2'b00;
    pulse(2'b01);
    expect_out(0, 1'b0, '0, "R5 selector cleared");
    settle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule